// File: doc/BRIEF.md
# Virtio Common Configuration Register Bank

This block is the register file behind the common-configuration window of a modern virtio PCI function. A simple register bus sends it byte-addressed reads and writes of 1, 2 or 4 bytes. Write data is right-justified on the bus and is cut to the access size before it is stored. A read returns its value, masked to the access size, one cycle after the request.

The bank holds two 32-bit feature-select registers, the device status byte, the configuration interrupt vector and a queue selector. Behind the selector sits a per-queue bank with a size, a vector, an enable and six 32-bit ring-address halves for each queue. The 64-bit device and driver feature words are reached through a 32-bit window whose half is picked by the matching select register.

The bank drives three outputs to the rest of the function. It presents the negotiated driver feature word, a one-cycle strobe on every status write, and the level and a one-cycle pulse for each queue enable. When the driver writes status 0, the device is put back to its defaults in a single clock edge.

Top module: `vcc_common_cfg`

## Requirements
- R1: A read at offset 0x04 returns the low half of the device feature word when the device-feature select (offset 0x00) is 0, the high half when it is 1, and zero for any larger select. The device feature word is the parameter mask ORed with bits 32 and 33 set.
- R2: A write at offset 0x0C stores its 32 bits into the low half of the driver features when the driver-feature select (offset 0x08) is 0, and into the high half when it is 1. The write is dropped when the select is above 1. The 64-bit result appears on `drv_features`. A read at 0x0C returns the selected half, or zero when the select is above 1.
- R3: Both feature-select registers are 32 bits wide and read back what was last written.
- R4: A write to queue select (offset 0x16, 16-bit) is ignored when the value is not below NUM_QUEUES. Otherwise it updates the selector. A read returns the current selector.
- R5: Queue size (0x18), queue vector (0x1A) and the ring halves are stored per queue and are reached through the current selector. The ring halves are, in 4-byte steps from 0x20: descriptor low, descriptor high, available low, available high, used low, used high.
- R6: A write to queue enable (0x1C) with a nonzero 16-bit value enables the selected queue and pulses its bit of `queue_en_pulse` for one cycle. A zero value disables the queue and gives no pulse. A read returns 1 or 0, and `queue_enabled` shows every queue's state.
- R7: The notify offset (0x1E) reads as the selector. The configuration generation (0x15) reads as 0. The number of queues (0x12) reads as NUM_QUEUES, and writes to it have no effect.
- R8: Device status (0x14) is 8 bits and readable. Every write to it raises `status_wr_pulse` for exactly one cycle, and `dev_status` shows the value.
- R9: Writing status 0 clears the driver features, both feature selects and the queue selector. It returns every queue to size QSIZE_DEFAULT, vector 0xFFFF, disabled and ring halves 0, and sets the configuration vector to 0xFFFF.
- R10: A read gives `rsp_valid` one cycle later, with data masked to the access size (code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). Offsets that hold no register read as zero. Write data is masked to the access size before it is stored.
- R11: The configuration vector (0x10) is a 16-bit read/write register.
- R12: After reset the outputs are idle and zero. The selectors are 0, the vectors are 0xFFFF, and the queue sizes are QSIZE_DEFAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the window |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, masked to size |
| drv_features | output | 64 | Negotiated driver feature word |
| dev_status | output | 8 | Current device status |
| status_wr_pulse | output | 1 | One-cycle strobe per status write |
| queue_enabled | output | NUM_QUEUES | Enable state per queue |
| queue_en_pulse | output | NUM_QUEUES | One-cycle pulse on an enabling write |

## Verification
A status write of zero does two things on the same clock edge: it raises the status strobe and it resets the feature, selector and queue state. The bench first loads nonzero driver features and enables several queues. It then writes status 0 and, in the cycle after that edge, checks that the strobe is high while `drv_features` and `queue_enabled` are already zero. Later reads confirm the default vectors, sizes and selectors. The feature windows and the queue selector are swept over every select value, including values out of range.

// File: rtl/vcc_pkg.sv
package vcc_pkg;

   localparam logic [7:0] OFF_DFSEL  = 8'h00;
   localparam logic [7:0] OFF_DF     = 8'h04;
   localparam logic [7:0] OFF_GFSEL  = 8'h08;
   localparam logic [7:0] OFF_GF     = 8'h0C;
   localparam logic [7:0] OFF_CVEC   = 8'h10;
   localparam logic [7:0] OFF_NUMQ   = 8'h12;
   localparam logic [7:0] OFF_STATUS = 8'h14;
   localparam logic [7:0] OFF_GEN    = 8'h15;
   localparam logic [7:0] OFF_QSEL   = 8'h16;
   localparam logic [7:0] OFF_QSIZE  = 8'h18;
   localparam logic [7:0] OFF_QVEC   = 8'h1A;
   localparam logic [7:0] OFF_QEN    = 8'h1C;
   localparam logic [7:0] OFF_QNOFF  = 8'h1E;
   localparam logic [7:0] OFF_RING0  = 8'h20;

   localparam int unsigned RING_HALVES = 6;
   localparam logic [15:0] VEC_NONE   = 16'hFFFF;

   typedef enum logic [3:0] {
      QF_NONE = 4'd0,
      QF_SIZE = 4'd1,
      QF_VEC  = 4'd2,
      QF_EN   = 4'd3,
      QF_DLO  = 4'd4,
      QF_DHI  = 4'd5,
      QF_ALO  = 4'd6,
      QF_AHI  = 4'd7,
      QF_ULO  = 4'd8,
      QF_UHI  = 4'd9
   } qfield_e;

   // map a window offset onto a banked queue field
   function automatic qfield_e field_at(input logic [7:0] off);
      case (off)
         OFF_QSIZE: return QF_SIZE;
         OFF_QVEC:  return QF_VEC;
         OFF_QEN:   return QF_EN;
         8'h20:     return QF_DLO;
         8'h24:     return QF_DHI;
         8'h28:     return QF_ALO;
         8'h2C:     return QF_AHI;
         8'h30:     return QF_ULO;
         8'h34:     return QF_UHI;
         default:   return QF_NONE;
      endcase
   endfunction

   function automatic logic [31:0] size_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [2:0] ring_index(input qfield_e f);
      logic [3:0] raw;
      raw = f;
      return 3'(raw - 4'd4);
   endfunction

endpackage

// File: rtl/vcc_feat.sv
module vcc_feat #(
   parameter logic [63:0] DEV_MASK = 64'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        wr_dsel,
   input  logic        wr_gsel,
   input  logic        wr_gf,
   input  logic [31:0] wdata,
   output logic [31:0] dsel,
   output logic [31:0] gsel,
   output logic [31:0] dev_half,
   output logic [31:0] drv_half,
   output logic [63:0] drv_feat
);
   localparam logic [63:0] DEV_WORD = DEV_MASK | 64'h0000_0003_0000_0000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dsel     <= '0;
         gsel     <= '0;
         drv_feat <= '0;
      end else if (clr) begin
         dsel     <= '0;
         gsel     <= '0;
         drv_feat <= '0;
      end else begin
         if (wr_dsel) dsel <= wdata;
         if (wr_gsel) gsel <= wdata;
         if (wr_gf && gsel == 32'd0) drv_feat[31:0]  <= wdata;
         if (wr_gf && gsel == 32'd1) drv_feat[63:32] <= wdata;
      end
   end

   always_comb begin
      case (dsel)
         32'd0:   dev_half = DEV_WORD[31:0];
         32'd1:   dev_half = DEV_WORD[63:32];
         default: dev_half = '0;
      endcase
      case (gsel)
         32'd0:   drv_half = drv_feat[31:0];
         32'd1:   drv_half = drv_feat[63:32];
         default: drv_half = '0;
      endcase
   end

   assert_drop_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_gf && gsel > 32'd1) |=> $stable(drv_feat));

   assert_clear_features_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (drv_feat == 64'd0 && gsel == 32'd0 && dsel == 32'd0));

endmodule

// File: rtl/vcc_qbank.sv
module vcc_qbank
   import vcc_pkg::*;
#(
   parameter int unsigned NQ          = 4,
   parameter int unsigned QSEL_W      = 2,
   parameter logic [15:0] QSIZE_DEF   = 16'd256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [QSEL_W-1:0] sel,
   input  logic              wr_en,
   input  qfield_e           wr_field,
   input  logic [31:0]       wdata,
   input  qfield_e           rd_field,
   output logic [31:0]       rd_val,
   output logic [NQ-1:0]     q_enabled,
   output logic [NQ-1:0]     q_en_pulse
);
   logic [15:0] sz_a [NQ];
   logic [15:0] vec_a [NQ];
   logic [RING_HALVES-1:0][31:0] ring_a [NQ];
   logic [2:0] wr_ridx;
   logic [2:0] rd_ridx;

   assign wr_ridx = ring_index(wr_field);
   assign rd_ridx = ring_index(rd_field);

   for (genvar i = 0; i < NQ; i++) begin : g_q
      logic        hit;
      logic [15:0] sz_r;
      logic [15:0] vec_r;
      logic        en_r;
      logic        pls_r;
      logic [RING_HALVES-1:0][31:0] ring_r;

      assign hit = wr_en && (sel == QSEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sz_r   <= QSIZE_DEF;
            vec_r  <= VEC_NONE;
            en_r   <= 1'b0;
            pls_r  <= 1'b0;
            ring_r <= '0;
         end else if (clr) begin
            sz_r   <= QSIZE_DEF;
            vec_r  <= VEC_NONE;
            en_r   <= 1'b0;
            pls_r  <= 1'b0;
            ring_r <= '0;
         end else begin
            pls_r <= hit && (wr_field == QF_EN) && (wdata[15:0] != 16'd0);
            if (hit) begin
               case (wr_field)
                  QF_SIZE: sz_r  <= wdata[15:0];
                  QF_VEC:  vec_r <= wdata[15:0];
                  QF_EN:   en_r  <= |wdata[15:0];
                  QF_DLO, QF_DHI, QF_ALO, QF_AHI, QF_ULO, QF_UHI:
                     ring_r[wr_ridx] <= wdata;
                  default: ;
               endcase
            end
         end
      end

      assign sz_a[i]       = sz_r;
      assign vec_a[i]      = vec_r;
      assign ring_a[i]     = ring_r;
      assign q_enabled[i]  = en_r;
      assign q_en_pulse[i] = pls_r;

      assert_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && wr_field == QF_EN && wdata[15:0] == 16'd0) |=>
            (!q_enabled[i] && !q_en_pulse[i]));

      assert_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && wr_field == QF_EN && wdata[15:0] != 16'd0) |=>
            (q_enabled[i] && q_en_pulse[i]));
   end

   always_comb begin
      case (rd_field)
         QF_SIZE: rd_val = {16'd0, sz_a[sel]};
         QF_VEC:  rd_val = {16'd0, vec_a[sel]};
         QF_EN:   rd_val = {31'd0, q_enabled[sel]};
         QF_DLO, QF_DHI, QF_ALO, QF_AHI, QF_ULO, QF_UHI:
                  rd_val = ring_a[sel][rd_ridx];
         default: rd_val = '0;
      endcase
   end

   assert_one_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(q_en_pulse));

endmodule

// File: rtl/vcc_rsp.sv
module vcc_rsp
   import vcc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rd,
   input  logic [1:0]  size,
   input  logic [31:0] raw,
   output logic        rsp_valid,
   output logic [31:0] rsp_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd;
         rsp_rdata <= rd ? (raw & size_mask(size)) : 32'd0;
      end
   end

   assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rsp_valid);

   assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rsp_valid);

   assert_byte_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && size == 2'd0) |=> (rsp_rdata[31:8] == 24'd0));

endmodule

// File: rtl/vcc_common_cfg.sv
module vcc_common_cfg
   import vcc_pkg::*;
#(
   parameter int unsigned NUM_QUEUES    = 4,
   parameter int unsigned ADDR_W        = 6,
   parameter logic [15:0] QSIZE_DEFAULT = 16'd256,
   parameter logic [63:0] DEV_FEAT_MASK = 64'h0000_0000_0000_0021
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid,
   input  logic                  bus_write,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [1:0]            bus_size,
   input  logic [31:0]           bus_wdata,
   output logic                  rsp_valid,
   output logic [31:0]           rsp_rdata,
   output logic [63:0]           drv_features,
   output logic [7:0]            dev_status,
   output logic                  status_wr_pulse,
   output logic [NUM_QUEUES-1:0] queue_enabled,
   output logic [NUM_QUEUES-1:0] queue_en_pulse
);
   localparam int unsigned QSEL_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
   localparam logic [31:0] NQ_W32 = 32'(NUM_QUEUES);

   if (NUM_QUEUES < 1 || NUM_QUEUES > 256) begin : g_bad_nq
      $error("NUM_QUEUES must lie in 1..256");
   end
   if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_aw
      $error("ADDR_W must lie in 6..8");
   end

   logic [7:0]        off;
   logic              wr;
   logic              rd;
   logic [31:0]       wm;
   logic              clr;
   qfield_e           fld;
   logic [QSEL_W-1:0] qsel;
   logic [15:0]       cfg_vec;
   logic [31:0]       dsel, gsel, dev_half, drv_half;
   logic [31:0]       q_rd;
   logic [31:0]       raw;

   assign off = 8'(bus_addr);
   assign wr  = bus_valid && bus_write;
   assign rd  = bus_valid && !bus_write;
   assign wm  = bus_wdata & size_mask(bus_size);
   assign clr = wr && (off == OFF_STATUS) && (wm[7:0] == 8'd0);
   assign fld = field_at(off);

   vcc_feat #(.DEV_MASK(DEV_FEAT_MASK)) u_feat (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .wr_dsel  (wr && off == OFF_DFSEL),
      .wr_gsel  (wr && off == OFF_GFSEL),
      .wr_gf    (wr && off == OFF_GF),
      .wdata    (wm),
      .dsel     (dsel),
      .gsel     (gsel),
      .dev_half (dev_half),
      .drv_half (drv_half),
      .drv_feat (drv_features)
   );

   // queue selector: a register only when there is more than one queue
   if (NUM_QUEUES > 1) begin : g_multi_q
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      qsel <= '0;
         else if (clr)    qsel <= '0;
         else if (wr && off == OFF_QSEL && {16'd0, wm[15:0]} < NQ_W32)
            qsel <= wm[QSEL_W-1:0];
      end
   end else begin : g_single_q
      assign qsel = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_vec         <= VEC_NONE;
         dev_status      <= 8'd0;
         status_wr_pulse <= 1'b0;
      end else begin
         status_wr_pulse <= wr && (off == OFF_STATUS);
         if (wr && off == OFF_STATUS) dev_status <= wm[7:0];
         if (clr)                     cfg_vec <= VEC_NONE;
         else if (wr && off == OFF_CVEC) cfg_vec <= wm[15:0];
      end
   end

   vcc_qbank #(
      .NQ        (NUM_QUEUES),
      .QSEL_W    (QSEL_W),
      .QSIZE_DEF (QSIZE_DEFAULT)
   ) u_qbank (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .sel        (qsel),
      .wr_en      (wr && fld != QF_NONE),
      .wr_field   (fld),
      .wdata      (wm),
      .rd_field   (fld),
      .rd_val     (q_rd),
      .q_enabled  (queue_enabled),
      .q_en_pulse (queue_en_pulse)
   );

   always_comb begin
      case (off)
         OFF_DFSEL:  raw = dsel;
         OFF_DF:     raw = dev_half;
         OFF_GFSEL:  raw = gsel;
         OFF_GF:     raw = drv_half;
         OFF_CVEC:   raw = {16'd0, cfg_vec};
         OFF_NUMQ:   raw = NQ_W32;
         OFF_STATUS: raw = {24'd0, dev_status};
         OFF_GEN:    raw = 32'd0;
         OFF_QSEL,
         OFF_QNOFF:  raw = 32'(qsel);
         default:    raw = (fld != QF_NONE) ? q_rd : 32'd0;
      endcase
   end

   vcc_rsp u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd        (rd),
      .size      (bus_size),
      .raw       (raw),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assert_status_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && off == OFF_STATUS) |=> status_wr_pulse);

   assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status_wr_pulse |-> $past(wr && off == OFF_STATUS));

   assert_qsel_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      32'(qsel) < NQ_W32);

   assert_bad_qsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && off == OFF_QSEL && {16'd0, wm[15:0]} >= NQ_W32) |=> $stable(qsel));

   assert_clear_queues_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (queue_enabled == '0 && drv_features == 64'd0));

endmodule

// File: tb/sim_vcc_common_cfg.sv
`timescale 1ns/1ps
module sim_vcc_common_cfg;
   localparam int unsigned NQ   = 4;
   localparam logic [63:0] MASK = 64'h0000_0004_1000_0021;
   localparam logic [15:0] QDEF = 16'd256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bv = 1'b0, bw = 1'b0;
   logic [5:0]  ba = '0;
   logic [1:0]  bs = '0;
   logic [31:0] bd = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [63:0] drv_features;
   logic [7:0]  dev_status;
   logic        status_wr_pulse;
   logic [NQ-1:0] queue_enabled, queue_en_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   vcc_common_cfg #(
      .NUM_QUEUES(NQ), .ADDR_W(6), .QSIZE_DEFAULT(QDEF), .DEV_FEAT_MASK(MASK)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
      .bus_size(bs), .bus_wdata(bd), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .drv_features(drv_features), .dev_status(dev_status),
      .status_wr_pulse(status_wr_pulse), .queue_enabled(queue_enabled),
      .queue_en_pulse(queue_en_pulse)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      bv = 1'b1; bw = 1'b1; ba = a; bs = s; bd = d;
      @(negedge clk);
      bv = 1'b0; bw = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [1:0] s, output logic [31:0] d);
      @(negedge clk);
      bv = 1'b1; bw = 1'b0; ba = a; bs = s; bd = '0;
      @(negedge clk);
      bv = 1'b0;
      chk("R10 rsp_valid", {63'd0, rsp_valid}, 64'd1);
      d = rsp_rdata;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic logic [31:0] ring_val(input int q, input int k);
      return 32'h1000_0000 * (k + 1) + 32'h0000_0011 * q + 32'h0000_0100 * k;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [63:0] exp_drv;
      logic [63:0] dev_word;
      int cur;
      dev_word = MASK | 64'h0000_0003_0000_0000;
      exp_drv  = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 rsp_valid", {63'd0, rsp_valid}, 64'd0);
      chk("R12 drv_features", drv_features, 64'd0);
      chk("R12 dev_status", {56'd0, dev_status}, 64'd0);
      chk("R12 status_wr_pulse", {63'd0, status_wr_pulse}, 64'd0);
      chk("R12 queue_enabled", {60'd0, queue_enabled}, 64'd0);
      rd(6'h10, 2'd1, r); chk("R12 R11 cfg vector default", {32'd0, r}, 64'hFFFF);
      rd(6'h16, 2'd1, r); chk("R12 qsel default", {32'd0, r}, 64'd0);
      rd(6'h18, 2'd1, r); chk("R12 qsize default", {32'd0, r}, {48'd0, QDEF});
      rd(6'h1A, 2'd1, r); chk("R12 qvec default", {32'd0, r}, 64'hFFFF);

      // R7 read-only and constant registers
      rd(6'h12, 2'd1, r); chk("R7 num queues", {32'd0, r}, NQ);
      wr(6'h12, 2'd1, 32'd9);
      rd(6'h12, 2'd1, r); chk("R7 num queues write ignored", {32'd0, r}, NQ);
      rd(6'h15, 2'd0, r); chk("R7 generation", {32'd0, r}, 64'd0);

      // R1, R3 device feature window sweep
      for (int s = 0; s < 4; s++) begin
         wr(6'h00, 2'd2, 32'(s));
         rd(6'h00, 2'd2, r); chk("R3 dev select readback", {32'd0, r}, 64'(s));
         rd(6'h04, 2'd2, r);
         chk("R1 dev features half", {32'd0, r},
             (s < 2) ? {32'd0, dev_word[32*s +: 32]} : 64'd0);
      end

      // R2, R3 driver feature window sweep
      for (int s = 0; s < 4; s++) begin
         wr(6'h08, 2'd2, 32'(s));
         rd(6'h08, 2'd2, r); chk("R3 drv select readback", {32'd0, r}, 64'(s));
         wr(6'h0C, 2'd2, 32'hA500_0000 + 32'(s) * 32'h0101);
         if (s == 0) exp_drv[31:0]  = 32'hA500_0000;
         if (s == 1) exp_drv[63:32] = 32'hA500_0101;
         chk("R2 drv features", drv_features, exp_drv);
         rd(6'h0C, 2'd2, r);
         chk("R2 drv half readback", {32'd0, r},
             (s < 2) ? {32'd0, exp_drv[32*s +: 32]} : 64'd0);
      end

      // R4 queue select sweep including out-of-range values
      cur = 0;
      for (int v = 0; v < 8; v++) begin
         wr(6'h16, 2'd1, 32'(v));
         if (v < NQ) cur = v;
         rd(6'h16, 2'd1, r); chk("R4 qsel", {32'd0, r}, 64'(cur));
      end

      // R5 banked queue registers
      for (int q = 0; q < NQ; q++) begin
         wr(6'h16, 2'd1, 32'(q));
         wr(6'h18, 2'd1, 32'(16 + 8 * q));
         wr(6'h1A, 2'd1, 32'h0100 + 32'(q));
         for (int k = 0; k < 6; k++) wr(6'(8'h20 + 4 * k), 2'd2, ring_val(q, k));
      end
      for (int q = 0; q < NQ; q++) begin
         wr(6'h16, 2'd1, 32'(q));
         rd(6'h18, 2'd1, r); chk("R5 qsize", {32'd0, r}, 64'(16 + 8 * q));
         rd(6'h1A, 2'd1, r); chk("R5 qvec", {32'd0, r}, 64'h0100 + 64'(q));
         rd(6'h1E, 2'd1, r); chk("R7 notify offset", {32'd0, r}, 64'(q));
         for (int k = 0; k < 6; k++) begin
            rd(6'(8'h20 + 4 * k), 2'd2, r);
            chk("R5 ring half", {32'd0, r}, {32'd0, ring_val(q, k)});
         end
      end

      // R6 enable and disable
      wr(6'h16, 2'd1, 32'd2);
      wr(6'h1C, 2'd1, 32'd5);
      chk("R6 enable pulse", {60'd0, queue_en_pulse}, 64'b0100);
      chk("R6 enabled level", {60'd0, queue_enabled}, 64'b0100);
      @(negedge clk);
      chk("R6 pulse one cycle", {60'd0, queue_en_pulse}, 64'd0);
      rd(6'h1C, 2'd1, r); chk("R6 enable readback", {32'd0, r}, 64'd1);
      wr(6'h1C, 2'd1, 32'd0);
      chk("R6 no pulse on disable", {60'd0, queue_en_pulse}, 64'd0);
      chk("R6 disabled level", {60'd0, queue_enabled}, 64'd0);
      rd(6'h1C, 2'd1, r); chk("R6 disable readback", {32'd0, r}, 64'd0);
      wr(6'h16, 2'd1, 32'd1); wr(6'h1C, 2'd1, 32'h8000);
      wr(6'h16, 2'd1, 32'd3); wr(6'h1C, 2'd1, 32'd1);
      chk("R6 two queues enabled", {60'd0, queue_enabled}, 64'b1010);

      // R8 status write
      wr(6'h14, 2'd0, 32'h0F);
      chk("R8 strobe", {63'd0, status_wr_pulse}, 64'd1);
      chk("R8 dev_status", {56'd0, dev_status}, 64'h0F);
      @(negedge clk);
      chk("R8 strobe one cycle", {63'd0, status_wr_pulse}, 64'd0);
      rd(6'h14, 2'd0, r); chk("R8 status readback", {32'd0, r}, 64'h0F);
      chk("R8 nonzero status keeps features", drv_features, exp_drv);

      // R10 and R11 size masking
      wr(6'h10, 2'd2, 32'h1234_ABCD);
      rd(6'h10, 2'd1, r); chk("R11 cfg vector word write", {32'd0, r}, 64'hABCD);
      rd(6'h10, 2'd0, r); chk("R10 byte read mask", {32'd0, r}, 64'hCD);
      wr(6'h10, 2'd0, 32'h0000_5577);
      rd(6'h10, 2'd1, r); chk("R10 byte write mask", {32'd0, r}, 64'h0077);
      wr(6'h16, 2'd1, 32'd3);
      rd(6'h2C, 2'd1, r); chk("R10 half read mask", {32'd0, r}, {48'd0, ring_val(3, 3)[15:0]});

      // R10 unused offsets
      for (int a = 8'h38; a < 8'h40; a++) begin
         rd(6'(a), 2'd2, r); chk("R10 unused offset", {32'd0, r}, 64'd0);
      end
      rd(6'h01, 2'd0, r); chk("R10 unused 0x01", {32'd0, r}, 64'd0);
      rd(6'h13, 2'd0, r); chk("R10 unused 0x13", {32'd0, r}, 64'd0);

      // R9 status 0: strobe and clear land on the same edge
      wr(6'h14, 2'd0, 32'h00);
      chk("R9 R8 strobe on clear", {63'd0, status_wr_pulse}, 64'd1);
      chk("R9 drv features cleared", drv_features, 64'd0);
      chk("R9 queues disabled", {60'd0, queue_enabled}, 64'd0);
      chk("R9 no enable pulse", {60'd0, queue_en_pulse}, 64'd0);
      rd(6'h16, 2'd1, r); chk("R9 qsel cleared", {32'd0, r}, 64'd0);
      rd(6'h00, 2'd2, r); chk("R9 dev select cleared", {32'd0, r}, 64'd0);
      rd(6'h08, 2'd2, r); chk("R9 drv select cleared", {32'd0, r}, 64'd0);
      rd(6'h10, 2'd1, r); chk("R9 cfg vector default", {32'd0, r}, 64'hFFFF);
      for (int q = 0; q < NQ; q++) begin
         wr(6'h16, 2'd1, 32'(q));
         rd(6'h18, 2'd1, r); chk("R9 qsize default", {32'd0, r}, {48'd0, QDEF});
         rd(6'h1A, 2'd1, r); chk("R9 qvec default", {32'd0, r}, 64'hFFFF);
         rd(6'h20, 2'd2, r); chk("R9 ring cleared", {32'd0, r}, 64'd0);
         rd(6'h34, 2'd2, r); chk("R9 ring cleared", {32'd0, r}, 64'd0);
      end

      done = 1;
      summary();
      $finish;
   end
endmodule